// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns external pin activity into interrupt requests for a processor. It has two clocked sense channels and one edge channel that captures its edge without the system clock. Each clocked channel samples its pin once, and then detects a low level, any change, a falling edge or a rising edge on the sampled value. The mode is set by a two-bit field. The edge channel captures a falling or rising edge, chosen by one polarity bit. The captured event is then carried into the clock domain through a two-flop synchronizer.

Each channel has a pending flag. An edge-type event sets the flag. The flag is cleared by a per-channel acknowledge or by software writing a one to it. In low-level mode nothing is stored: the channel requests only while its sampled pin stays low. A pending channel raises the registered request output only when its mask bit and the global enable are both set. When several channels qualify, the lowest channel number wins, and its number is reported next to the request.

Software reaches the modes, masks and flags through a small register port. Writes take effect on the clock edge. Reads return the data one cycle after the address.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every mode bit, the polarity bit, every mask bit and every flag read as zero, and `irq_req` is low. Pins held high through reset produce no event afterwards.
- R2: A clocked channel with mode 00 reports pending while its sampled pin is low and stops as soon as it is high. Nothing is stored, so the flag reads 0 after the pin returns high.
- R3: A clocked channel with mode 01 sets its flag on both rising and falling sampled edges.
- R4: A clocked channel with mode 10 sets its flag on a falling edge only.
- R5: A clocked channel with mode 11 sets its flag on a rising edge only.
- R6: `irq_req` is high only when the global enable `gie` and the pending channel's mask bit are both set. Requests are registered, one cycle after the pending state.
- R7: On the edge channel, polarity 0 selects falling edges and polarity 1 selects rising edges. The opposite edge sets nothing.
- R8: Changing the polarity bit while the pin makes the newly selected level active sets the edge channel's flag.
- R9: Writing address 2 clears each flag whose data bit is one. Data bits of zero leave the flags as they are.
- R10: An `ack` bit clears that channel's flag. A new event in the same cycle as the acknowledge or clear wins, and the flag stays set.
- R11: Priority is channel 0, then channel 1, then the edge channel. `irq_id` reports 0, 1 or 2.
- R12: Register map:
  - Address 0 holds channel 0 mode in bits [1:0], channel 1 mode in bits [3:2] and polarity in bit 4.
  - Address 1 holds the masks in bits [2:0].
  - Address 2 holds the pending state in bits [2:0].
  - Address 3 reads zero.
  - Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_s | input | 2 | Pins of the clocked sense channels |
| pin_a | input | 1 | Pin of the edge channel |
| gie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| ack | input | 3 | Per-channel acknowledge, bit 2 is the edge channel |
| irq_req | output | 1 | Registered interrupt request |
| irq_id | output | 2 | Number of the winning channel |

## Verification
A fresh pin event can arrive in the same cycle as that channel's acknowledge. The bench provokes this on channel 0 in any-change mode. It toggles the pin and holds `ack[0]` for exactly the cycle in which the sampled edge is seen. It then reads the flag back and requires it to still be set. A separate acknowledge afterwards must clear it. The same set-over-clear rule holds for a write-one-clear to address 2, and a bound assertion watches it for the edge channel.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int ADR_CTRL = 0;
  localparam int ADR_MASK = 1;
  localparam int ADR_FLAG = 2;
endpackage

// File: rtl/sync_sense_chan.sv
module sync_sense_chan
  import irq_sense_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pin,
  input  sense_e mode,
  input  logic   clr,
  output logic   ev,
  output logic   pend
);
  logic smp_q, prv_q, flag_q;

  // event on the sampled pin value
  always_comb begin
    case (mode)
      SENSE_ANY:  ev = smp_q ^ prv_q;
      SENSE_FALL: ev = prv_q & ~smp_q;
      SENSE_RISE: ev = ~prv_q & smp_q;
      default:    ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= pin;
      prv_q  <= pin;
      flag_q <= 1'b0;
    end else begin
      smp_q <= pin;
      prv_q <= smp_q;
      if (mode == SENSE_LOW) flag_q <= 1'b0;
      else if (ev)           flag_q <= 1'b1;
      else if (clr)          flag_q <= 1'b0;
    end
  end

  assign pend = (mode == SENSE_LOW) ? ~smp_q : flag_q;
endmodule

// File: rtl/async_edge_chan.sv
module async_edge_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic pol,
  input  logic clr,
  output logic ev,
  output logic pend
);
  logic trig, cap_q, flag_q;
  logic [SYNC_STAGES:0] sh_q;

  // selected edge becomes a rising edge of trig
  assign trig = pol ? pin : ~pin;

  // toggle capture, no system clock involved
  always_ff @(posedge trig or posedge rst) begin
    if (rst) cap_q <= 1'b0;
    else     cap_q <= ~cap_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      sh_q <= {sh_q[SYNC_STAGES-1:0], cap_q};
      if (ev)       flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign ev   = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];
  assign pend = flag_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N    = 3,
  parameter int ID_W = 2
) (
  input  logic [N-1:0]    pend,
  input  logic [N-1:0]    mask,
  input  logic            gie,
  output logic            req,
  output logic [ID_W-1:0] id
);
  logic [N-1:0] live;
  assign live = pend & mask;

  always_comb begin
    id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) id = ID_W'(i);
    end
  end

  assign req = gie & (|live);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import irq_sense_pkg::*;
#(
  parameter int NUM_SYNC    = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SYNC-1:0]           pin_s,
  input  logic                          pin_a,
  input  logic                          gie,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  input  logic [NUM_SYNC:0]             ack,
  output logic                          irq_req,
  output logic [$clog2(NUM_SYNC+1)-1:0] irq_id
);
  localparam int NCH    = NUM_SYNC + 1;
  localparam int ID_W   = $clog2(NCH);
  localparam int CTRL_W = 2 * NUM_SYNC + 1;
  localparam int POL_B  = 2 * NUM_SYNC;

  sense_e   mode_q [NUM_SYNC];
  logic     pol_q;
  logic [NCH-1:0] mask_q, pend_w, ev_w, clr_w;
  logic     wr_ctrl, wr_mask, wr_flag;
  logic     req_w;
  logic [ID_W-1:0] id_w;
  logic [CTRL_W-1:0] ctrl_rd;
  logic     unused_wdata;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
  assign wr_mask = wr_en && (wr_addr == ADDR_W'(ADR_MASK));
  assign wr_flag = wr_en && (wr_addr == ADDR_W'(ADR_FLAG));
  assign clr_w   = ack | ({NCH{wr_flag}} & wr_data[NCH-1:0]);
  assign unused_wdata = ^wr_data[DATA_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SYNC; i++) mode_q[i] <= SENSE_LOW;
      pol_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        for (int i = 0; i < NUM_SYNC; i++) mode_q[i] <= sense_e'(wr_data[2*i +: 2]);
        pol_q <= wr_data[POL_B];
      end
      if (wr_mask) mask_q <= wr_data[NCH-1:0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SYNC; g++) begin : g_sync
      sync_sense_chan u_ch (
        .clk  (clk),
        .rst  (rst),
        .pin  (pin_s[g]),
        .mode (mode_q[g]),
        .clr  (clr_w[g]),
        .ev   (ev_w[g]),
        .pend (pend_w[g])
      );
      assign ctrl_rd[2*g +: 2] = mode_q[g];
    end
  endgenerate
  assign ctrl_rd[POL_B] = pol_q;

  async_edge_chan #(.SYNC_STAGES(SYNC_STAGES)) u_ach (
    .clk  (clk),
    .rst  (rst),
    .pin  (pin_a),
    .pol  (pol_q),
    .clr  (clr_w[NUM_SYNC]),
    .ev   (ev_w[NUM_SYNC]),
    .pend (pend_w[NUM_SYNC])
  );

  irq_prio #(.N(NCH), .ID_W(ID_W)) u_prio (
    .pend (pend_w),
    .mask (mask_q),
    .gie  (gie),
    .req  (req_w),
    .id   (id_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_id  <= '0;
      rd_data <= '0;
    end else begin
      irq_req <= req_w;
      irq_id  <= req_w ? id_w : '0;
      case (int'(rd_addr))
        ADR_CTRL: rd_data <= DATA_W'(ctrl_rd);
        ADR_MASK: rd_data <= DATA_W'(mask_q);
        ADR_FLAG: rd_data <= DATA_W'(pend_w);
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int NCH  = 3,
  parameter int ID_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            gie,
  input logic            irq_req,
  input logic [ID_W-1:0] irq_id,
  input logic [NCH-1:0]  pend,
  input logic [NCH-1:0]  ev,
  input logic [NCH-1:0]  mask,
  input logic [NCH-1:0]  ack
);
  // R6: request only follows an enabled cycle
  a_r6_gie_gate: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(gie));

  // R6: request needs a masked-in pending channel one cycle earlier
  a_r6_mask_gate: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(|(pend & mask)));

  // R11: channel 1 wins only when channel 0 was not live
  a_r11_prio: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_id == ID_W'(1)) |-> $past(!(pend[0] && mask[0])));

  // R11: id stays in range
  a_r11_id_range: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_id < ID_W'(NCH)));

  // R10: acknowledge clears the edge channel flag unless a new event arrives
  a_r10_ack_clear: assert property (@(posedge clk) disable iff (rst)
    (ack[NCH-1] && !ev[NCH-1]) |=> !pend[NCH-1]);

  // R10: a new event always leaves the flag set
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    ev[NCH-1] |=> pend[NCH-1]);
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NCH(NCH), .ID_W(ID_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .gie     (gie),
  .irq_req (irq_req),
  .irq_id  (irq_id),
  .pend    (pend_w),
  .ev      (ev_w),
  .mask    (mask_q),
  .ack     (ack)
);

// File: tb/sim_ext_irq_sense.sv
module sim_ext_irq_sense;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] pin_s;
  logic       pin_a, gie, wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [2:0] ack;
  logic       irq_req;
  logic [1:0] irq_id;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] rv;

  // {mode[1:0], pin before, pin after, expected flag bit 0}
  localparam logic [4:0] VEC [0:7] = '{
    5'b00_1_0_1, 5'b00_0_1_0,
    5'b01_1_0_1, 5'b01_0_1_1,
    5'b10_1_0_1, 5'b10_0_1_0,
    5'b11_1_0_0, 5'b11_0_1_1
  };

  always #(CLK_NS/2) clk = ~clk;

  ext_irq_sense u0 (
    .clk(clk), .rst(rst), .pin_s(pin_s), .pin_a(pin_a), .gie(gie),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ack(ack),
    .irq_req(irq_req), .irq_id(irq_id)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse_ack(input logic [2:0] m);
    @(negedge clk);
    ack = m;
    @(negedge clk);
    ack = 3'b000;
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; pin_s = 2'b11; pin_a = 1'b1; gie = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0; ack = '0;
    idle(4);
    rst = 1'b0;
    idle(4);

    // R1 reset state
    chk("R1 irq_req", irq_req, 1'b0);
    rd(2'd0, rv); chk("R1 ctrl", rv, 8'h00);
    rd(2'd1, rv); chk("R1 mask", rv, 8'h00);
    rd(2'd2, rv); chk("R1 flags", rv, 8'h00);
    wr(2'd0, 8'h05);            // both clocked channels any-change, pins still high
    idle(4);
    rd(2'd2, rv); chk("R1 no false edge", rv, 8'h00);
    rd(2'd3, rv); chk("R12 unused address", rv, 8'h00);
    rd(2'd0, rv); chk("R12 ctrl readback", rv, 8'h05);

    // R6 gating
    pin_s = 2'b00; idle(3);
    wr(2'd0, 8'h03); wr(2'd2, 8'h07); idle(2);
    pin_s[0] = 1'b1; idle(4);
    rd(2'd2, rv); chk("R5 rise flag", rv[0], 1'b1);
    chk("R6 masked off", irq_req, 1'b0);
    wr(2'd1, 8'h01); idle(2);
    chk("R6 gie off", irq_req, 1'b0);
    gie = 1'b1; idle(2);
    chk("R6 enabled req", irq_req, 1'b1);
    chk("R11 id ch0", irq_id, 2'd0);
    rd(2'd1, rv); chk("R12 mask readback", rv, 8'h01);

    // R2 level mode, live only
    wr(2'd0, 8'h00); idle(2);
    chk("R2 pin high no req", irq_req, 1'b0);
    pin_s[0] = 1'b0; idle(3);
    chk("R2 pin low req", irq_req, 1'b1);
    pin_s[0] = 1'b1; idle(3);
    chk("R2 released", irq_req, 1'b0);
    rd(2'd2, rv); chk("R2 not stored", rv[0], 1'b0);
    gie = 1'b0;

    // R10 event in the same cycle as acknowledge
    wr(2'd0, 8'h01); idle(2);
    pin_s[0] = 1'b0; idle(4);
    rd(2'd2, rv); chk("R3 fall flag", rv[0], 1'b1);
    pin_s[0] = 1'b1;            // sampled at next edge E1, event seen until E2
    @(negedge clk); ack = 3'b001; // held for the edge E2
    @(negedge clk); ack = 3'b000;
    idle(1);
    rd(2'd2, rv); chk("R10 set wins over ack", rv[0], 1'b1);
    pulse_ack(3'b001); idle(1);
    rd(2'd2, rv); chk("R10 ack clears", rv[0], 1'b0);

    // R7 edge channel polarity 0
    pin_a = 1'b1; wr(2'd0, 8'h00); idle(5);
    wr(2'd2, 8'h07); idle(2);
    pin_a = 1'b0; idle(6);
    rd(2'd2, rv); chk("R7 falling pol0", rv[2], 1'b1);
    wr(2'd2, 8'h03); idle(1);
    rd(2'd2, rv); chk("R9 zero bit keeps flag", rv[2], 1'b1);
    wr(2'd2, 8'h04); idle(1);
    rd(2'd2, rv); chk("R9 one bit clears", rv[2], 1'b0);
    pin_a = 1'b1; idle(6);
    rd(2'd2, rv); chk("R7 rising ignored pol0", rv[2], 1'b0);

    // R8 polarity change with pin high
    wr(2'd0, 8'h10); idle(6);
    rd(2'd2, rv); chk("R8 pol change sets flag", rv[2], 1'b1);
    wr(2'd2, 8'h04); idle(2);
    pin_a = 1'b0; idle(6);
    rd(2'd2, rv); chk("R7 falling ignored pol1", rv[2], 1'b0);

    // R11 priority walk
    pin_s = 2'b00; pin_a = 1'b0;
    wr(2'd0, 8'h1F); idle(3);
    wr(2'd2, 8'h07); wr(2'd1, 8'h07); gie = 1'b1; idle(2);
    chk("R6 idle no req", irq_req, 1'b0);
    pin_s = 2'b11; pin_a = 1'b1; idle(6);
    chk("R11 all pending id0", irq_id, 2'd0);
    pulse_ack(3'b001); idle(1);
    chk("R11 next id1", irq_id, 2'd1);
    pulse_ack(3'b010); idle(1);
    chk("R11 next id2", irq_id, 2'd2);
    chk("R7 rising pol1 req", irq_req, 1'b1);
    pulse_ack(3'b100); idle(1);
    chk("R10 all acked", irq_req, 1'b0);
    gie = 1'b0;

    // sense mode table on channel 0 (R2 R3 R4 R5)
    for (int k = 0; k < 8; k++) begin
      pin_s[0] = VEC[k][2];
      wr(2'd0, {6'b0, VEC[k][4:3]});
      idle(3);
      wr(2'd2, 8'h01); idle(2);
      pin_s[0] = VEC[k][1];
      idle(4);
      rd(2'd2, rv);
      chk($sformatf("R2 R3 R4 R5 mode %0b vector %0d", VEC[k][4:3], k), rv[0], VEC[k][0]);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule